// File: doc/BRIEF.md
# Six-Bridge Gate Sequencer with Non-Overlap Timing

This block turns per-bridge drive requests into gate commands for the high-side and low-side switch of each of six half-bridges. Each bridge has an enable bit and a direction bit. A per-bridge fault-off mask and a global supply lockout come from a fault supervisor. Enable low, an active fault-off bit or an active lockout puts the bridge in high impedance. Otherwise the direction bit picks the low side (sink, direction 0) or the high side (source, direction 1).

The enable, direction and fault inputs are first reduced to a two-bit request per bridge: off, sink or source. Each bridge then runs a four-state sequencer (off, low on, high on, dead). The two switches of a bridge are never commanded on together. Whenever a driving side is released, both gates stay off for a fixed number of clock cycles before either side may turn on again. A bridge that is fully idle starts driving on the next cycle. Registered status bits report the effective enable and direction of each bridge after all masking.

Top module: `hb_gate_ctrl`

## Requirements
- R1: During reset and in the first cycle after it, every hs_on and ls_on bit is 0 and every stat_en and stat_dir bit is 0.
- R2: A bridge whose effective enable (bridge_en=1, fault_off=0, supply_lockout=0) is 0 has hs_on=0 and ls_on=0 one cycle later, whatever bridge_dir is.
- R3: An effectively enabled bridge with bridge_dir=0 drives ls_on=1 and hs_on=0 once any pending non-overlap interval has elapsed.
- R4: An effectively enabled bridge with bridge_dir=1 drives hs_on=1 and ls_on=0 once any pending non-overlap interval has elapsed.
- R5: hs_on[i] and ls_on[i] are never 1 in the same cycle.
- R6: When a bridge changes from one driving side to the other, both gates are 0 for exactly DEAD_CYCLES cycles, and the new side turns on in the following cycle.
- R7: A bridge that has been off for at least DEAD_CYCLES cycles turns on the requested side in the first cycle after the request is applied.
- R8: fault_off[i]=1 forces only bridge i off. The other bridges keep their state.
- R9: While supply_lockout=1, all gates are 0. After it drops, each bridge returns to the side given by its unchanged inputs without new programming.
- R10: stat_en[i] equals the effective enable and stat_dir[i] equals bridge_dir[i] AND the effective enable, both one cycle after the inputs.
- R11: A request for a side made while a previously driving side is still in its non-overlap interval after release waits for that interval to end. The side turns on DEAD_CYCLES+1 cycles after the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bridge_en | input | NUM_BRIDGES | Per-bridge drive enable |
| bridge_dir | input | NUM_BRIDGES | Per-bridge direction: 0 sink (low side), 1 source (high side) |
| fault_off | input | NUM_BRIDGES | Per-bridge forced-off mask from the supervisor |
| supply_lockout | input | 1 | Global forced-off from a supply fault |
| hs_on | output | NUM_BRIDGES | High-side gate commands |
| ls_on | output | NUM_BRIDGES | Low-side gate commands |
| stat_en | output | NUM_BRIDGES | Effective enable per bridge, registered |
| stat_dir | output | NUM_BRIDGES | Effective direction per bridge, registered |

## Verification
The hardest case is a request that arrives while a released side is still inside its non-overlap interval. The bridge is not yet idle, so a side must not turn on at once, even though its inputs look like a plain turn-on from high impedance. The bench reaches this case by dropping the enable of a driving bridge for a single cycle and then requesting the opposite side. It also sweeps every pair of start and end input codes (enable, direction, fault) and checks the gates cycle by cycle across the whole interval, using a small dead-time value.

// File: rtl/hb_gate_pkg.sv
package hb_gate_pkg;

    typedef enum logic [1:0] {
        REQ_OFF = 2'b00,
        REQ_LS  = 2'b01,
        REQ_HS  = 2'b10
    } leg_req_t;

    typedef enum logic [1:0] {
        ST_OFF  = 2'b00,
        ST_LS   = 2'b01,
        ST_HS   = 2'b10,
        ST_DEAD = 2'b11
    } leg_state_t;

endpackage

// File: rtl/hb_decode.sv
module hb_decode
    import hb_gate_pkg::*;
(
    input  logic     en_i,
    input  logic     dir_i,
    input  logic     fault_i,
    input  logic     lock_i,
    output leg_req_t req_o,
    output logic     eff_en_o,
    output logic     eff_dir_o
);

    always_comb begin
        eff_en_o  = en_i && !fault_i && !lock_i;
        eff_dir_o = eff_en_o && dir_i;
        if (!eff_en_o) begin
            req_o = REQ_OFF;
        end else if (dir_i) begin
            req_o = REQ_HS;
        end else begin
            req_o = REQ_LS;
        end
    end

endmodule

// File: rtl/hb_leg.sv
module hb_leg
    import hb_gate_pkg::*;
#(
    parameter int DEAD_CYCLES = 300
) (
    input  logic     clk,
    input  logic     rst_n,
    input  leg_req_t req_i,
    output logic     hs_o,
    output logic     ls_o
);

    localparam int CW = $clog2(DEAD_CYCLES + 1);
    localparam logic [CW-1:0] CNT_LOAD = CW'(DEAD_CYCLES - 1);
    localparam logic [CW-1:0] GAP_MAX  = CW'(DEAD_CYCLES);

    typedef struct packed {
        leg_state_t    state;
        logic [CW-1:0] cnt;
        logic [CW-1:0] gap;
    } leg_reg_t;

    leg_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (r_q.state)
            ST_OFF: begin
                if (req_i == REQ_LS) begin
                    r_d.state = ST_LS;
                end else if (req_i == REQ_HS) begin
                    r_d.state = ST_HS;
                end
            end
            ST_LS: begin
                if (req_i != REQ_LS) begin
                    r_d.state = ST_DEAD;
                    r_d.cnt   = CNT_LOAD;
                end
            end
            ST_HS: begin
                if (req_i != REQ_HS) begin
                    r_d.state = ST_DEAD;
                    r_d.cnt   = CNT_LOAD;
                end
            end
            default: begin
                if (r_q.cnt == '0) begin
                    case (req_i)
                        REQ_LS:  r_d.state = ST_LS;
                        REQ_HS:  r_d.state = ST_HS;
                        default: r_d.state = ST_OFF;
                    endcase
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
        endcase
        // Cycles with both gates off, saturating; feeds the interval check.
        if (r_d.state == ST_LS || r_d.state == ST_HS) begin
            r_d.gap = '0;
        end else if (r_q.gap < GAP_MAX) begin
            r_d.gap = r_q.gap + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state <= ST_OFF;
            r_q.cnt   <= '0;
            r_q.gap   <= GAP_MAX;
        end else begin
            r_q <= r_d;
        end
    end

    assign hs_o = (r_q.state == ST_HS);
    assign ls_o = (r_q.state == ST_LS);

    p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_o && ls_o));

    p_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hs_o) || $rose(ls_o)) |-> ($past(r_q.gap) >= GAP_MAX));

    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i == REQ_OFF) |=> (!hs_o && !ls_o));

    p_fromz_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_OFF && req_i == REQ_HS) |=> hs_o);

    p_hold_ls_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_o && req_i == REQ_LS) |=> ls_o);

    p_hold_hs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_o && req_i == REQ_HS) |=> hs_o);

endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl
    import hb_gate_pkg::*;
#(
    parameter int NUM_BRIDGES = 6,
    parameter int DEAD_CYCLES = 300
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_BRIDGES-1:0] bridge_en,
    input  logic [NUM_BRIDGES-1:0] bridge_dir,
    input  logic [NUM_BRIDGES-1:0] fault_off,
    input  logic                   supply_lockout,
    output logic [NUM_BRIDGES-1:0] hs_on,
    output logic [NUM_BRIDGES-1:0] ls_on,
    output logic [NUM_BRIDGES-1:0] stat_en,
    output logic [NUM_BRIDGES-1:0] stat_dir
);

    typedef struct packed {
        logic [NUM_BRIDGES-1:0] en;
        logic [NUM_BRIDGES-1:0] dir;
    } stat_reg_t;

    stat_reg_t              s_d, s_q;
    logic [NUM_BRIDGES-1:0] eff_en, eff_dir;

    for (genvar i = 0; i < NUM_BRIDGES; i++) begin : g_bridge
        leg_req_t req;

        hb_decode u_dec (
            .en_i      (bridge_en[i]),
            .dir_i     (bridge_dir[i]),
            .fault_i   (fault_off[i]),
            .lock_i    (supply_lockout),
            .req_o     (req),
            .eff_en_o  (eff_en[i]),
            .eff_dir_o (eff_dir[i])
        );

        hb_leg #(.DEAD_CYCLES(DEAD_CYCLES)) u_leg (
            .clk   (clk),
            .rst_n (rst_n),
            .req_i (req),
            .hs_o  (hs_on[i]),
            .ls_o  (ls_on[i])
        );
    end

    always_comb begin
        s_d     = s_q;
        s_d.en  = eff_en;
        s_d.dir = eff_dir;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign stat_en  = s_q.en;
    assign stat_dir = s_q.dir;

    p_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
        supply_lockout |=> (hs_on == '0 && ls_on == '0));

    p_statsub_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_dir & ~stat_en) == '0);

endmodule

// File: tb/tb_hb_gate_ctrl.sv
module tb_hb_gate_ctrl;

    localparam int NB   = 6;
    localparam int DEAD = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NB-1:0] bridge_en = '0, bridge_dir = '0, fault_off = '0;
    logic          supply_lockout = 1'b0;
    logic [NB-1:0] hs_on, ls_on, stat_en, stat_dir;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    hb_gate_ctrl #(.NUM_BRIDGES(NB), .DEAD_CYCLES(DEAD)) dut (
        .clk(clk), .rst_n(rst_n), .bridge_en(bridge_en), .bridge_dir(bridge_dir),
        .fault_off(fault_off), .supply_lockout(supply_lockout),
        .hs_on(hs_on), .ls_on(ls_on), .stat_en(stat_en), .stat_dir(stat_dir)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Advance one cycle; sample/drive 1 ns after the rising edge.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Continuous R5 monitor, sampled away from the edge.
    always @(negedge clk) begin
        if (rst_n && !done) chk("R5 exclusive gates", 32'(hs_on & ls_on), 32'd0);
    end

    // side: 0 off, 1 low, 2 high
    function automatic int side_of(input int code);
        if (!code[0] || code[2]) return 0;
        return code[1] ? 2 : 1;
    endfunction

    task automatic apply(input int code);
        bridge_en  = {NB{code[0]}};
        bridge_dir = {NB{code[1]}};
        fault_off  = {NB{code[2]}};
    endtask

    initial begin
        #200000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        step();
        chk("R1 hs in reset", 32'(hs_on), 32'd0);
        chk("R1 ls in reset", 32'(ls_on), 32'd0);
        bridge_en = '1; bridge_dir = 6'b101010;
        step();
        rst_n = 1'b1;
        bridge_en = '0;
        step();
        chk("R1 hs after reset", 32'(hs_on), 32'd0);
        chk("R1 stat after reset", 32'({stat_en, stat_dir}), 32'd0);

        // Exhaustive start/end sweep over {fault,dir,en}.
        for (int s = 0; s < 8; s++) begin
            for (int e = 0; e < 8; e++) begin
                int ss, es, ex;
                string tag;
                apply(s);
                for (int k = 0; k < DEAD + 3; k++) step();
                ss = side_of(s);
                es = side_of(e);
                chk("R3/R4 settled hs", 32'(hs_on), ss == 2 ? 32'h3f : 32'd0);
                chk("R3/R4 settled ls", 32'(ls_on), ss == 1 ? 32'h3f : 32'd0);
                apply(e);
                for (int c = 1; c <= DEAD + 2; c++) begin
                    step();
                    if (ss == es || ss == 0) begin
                        ex = es;
                        tag = (ss == 0 && es != 0) ? "R7 from high-z" : "R2/R3/R4 steady";
                    end else begin
                        ex = (c <= DEAD) ? 0 : es;
                        tag = (es == 0) ? "R2 release" : "R6 handover";
                    end
                    chk(tag, 32'(hs_on), ex == 2 ? 32'h3f : 32'd0);
                    chk(tag, 32'(ls_on), ex == 1 ? 32'h3f : 32'd0);
                    if (c == 1) begin
                        chk("R10 stat_en", 32'(stat_en), es != 0 ? 32'h3f : 32'd0);
                        chk("R10 stat_dir", 32'(stat_dir), es == 2 ? 32'h3f : 32'd0);
                    end
                end
            end
        end

        // R8: per-bridge fault mask.
        apply(1);
        bridge_dir = 6'b000111;
        for (int k = 0; k < DEAD + 3; k++) step();
        fault_off = 6'b000100;
        step();
        chk("R8 masked bridge hs", 32'(hs_on), 32'h03);
        chk("R8 others ls", 32'(ls_on), 32'h38);
        chk("R8 stat_en", 32'(stat_en), 32'h3b);
        fault_off = '0;
        for (int k = 0; k < DEAD + 3; k++) step();

        // R9: global lockout.
        bridge_dir = 6'b101010;
        for (int k = 0; k < DEAD + 3; k++) step();
        supply_lockout = 1'b1;
        step();
        chk("R9 lockout hs", 32'(hs_on), 32'd0);
        chk("R9 lockout ls", 32'(ls_on), 32'd0);
        chk("R10 lockout stat", 32'(stat_en), 32'd0);
        for (int k = 0; k < DEAD + 3; k++) step();
        chk("R9 still off", 32'(hs_on | ls_on), 32'd0);
        supply_lockout = 1'b0;
        step();
        chk("R9 resume hs", 32'(hs_on), 32'h2a);
        chk("R9 resume ls", 32'(ls_on), 32'h15);
        chk("R10 resume stat_dir", 32'(stat_dir), 32'h2a);

        // R11: brief release then opposite request during interval.
        bridge_dir = '0;
        for (int k = 0; k < DEAD + 3; k++) step();
        chk("R11 start low", 32'(ls_on), 32'h3f);
        bridge_en = '0;
        step();
        bridge_en = '1; bridge_dir = '1;
        for (int c = 2; c <= DEAD; c++) step();
        chk("R11 still waiting", 32'(hs_on | ls_on), 32'd0);
        step();
        chk("R11 high after interval", 32'(hs_on), 32'h3f);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule